// File: doc/BRIEF.md
# Double-Buffered Switch Configuration Loader

This block holds the control bits for a multiplexer-based switching network. Each stored routing application has a call number. Its configuration words sit in a small parameterised table, with one word for each node of the network. When a valid call number arrives together with an enable pulse, a sequencer reads that call's words one per cycle. Each word goes over an address and data path, and a decoder writes it into the staging register of the matching node.

Once the last word is staged, the sequencer issues a single-cycle commit without any further command. The commit copies every staging register into the live configuration register at the same clock edge. The whole new routing therefore appears at once, and the network never sees a half-written configuration. A done flag then tells the host that the target application can start. The flag stays up until the next load is accepted.

Top module: `route_cfg_stager`

## Requirements
- R1: While reset is held and after it is released, the live configuration output is all zero, `busy` is low and `done` is low.
- R2: In the idle or done state, an enable with a call number from 0 to 3 is accepted. Starting from the next edge, `busy` is high for exactly NODES+1 cycles: NODES cycles of staging and one commit cycle.
- R3: After a load of call c, field n of `cfg_bits` (bits n*WORD_W and up, WORD_W wide) equals (c*71 + n*19 + 33) mod 2^WORD_W.
- R4: `cfg_bits` holds its previous value during staging. All fields change together at the edge NODES+1 cycles after the accepting edge.
- R5: `done` rises at the same edge as the configuration update. It stays high until an enable is accepted, and it falls at the edge that accepts that enable.
- R6: An enable with a call number from 4 to 7 is ignored. The state, `busy`, `done` and `cfg_bits` stay unchanged.
- R7: An enable that arrives while `busy` is high is ignored. The load in progress completes with its original call.
- R8: A new load may be started from the done state, and it replaces the whole previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| call_id | input | ID_W (3) | Call number of the routing application |
| cfg_en | input | 1 | Start request, sampled at the clock edge |
| cfg_bits | output | NODES*WORD_W (64) | Live configuration registers, node 0 in the low bits |
| busy | output | 1 | Staging or commit in progress |
| done | output | 1 | New configuration is live |

## Verification
An enable that is accepted at edge k makes `busy` rise at edge k and fall at edge k+NODES+1. The configuration update and the rise of `done` land together at edge k+NODES+1. The bench drives inputs on the falling edge and advances a behavioural reference model at each rising edge. It then compares `busy`, `done` and the full `cfg_bits` against that model on every falling edge, so every deadline is checked in the cycle where it falls due. Targeted checks count the busy window and sample single fields after the commit. They also probe ignored enables, both during a load and with call numbers outside 0 to 3.

// File: rtl/cfgld_pkg.sv
// Package: shared types for the configuration loader.
// Assumes nothing beyond a two-bit state encoding.
package cfgld_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_COMMIT = 2'd2,
        ST_DONE   = 2'd3
    } ld_state_e;
endpackage

// File: rtl/cfg_table_rom.sv
// Module: cfg_table_rom
// Computed read-only table of configuration words, one word per (call, node).
// Assumes WORD_W <= 32; the contents follow (c*71 + n*19 + 33) mod 2^WORD_W.
module cfg_table_rom #(
    parameter int CALLS  = 4,
    parameter int NODES  = 8,
    parameter int WORD_W = 8,
    parameter int CALL_W = 2,
    parameter int ADDR_W = 3
) (
    input  logic [CALL_W-1:0] call_sel,
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] word
);
    localparam int ENTRIES = CALLS * NODES;

    logic [WORD_W-1:0] rom_w [ENTRIES];

    // Builds each table entry from its call and node numbers.
    for (genvar c = 0; c < CALLS; c++) begin : g_call
        for (genvar n = 0; n < NODES; n++) begin : g_node
            localparam int VAL = c * 71 + n * 19 + 33;
            localparam logic [31:0] VAL_V = VAL;
            assign rom_w[c*NODES+n] = VAL_V[WORD_W-1:0];
        end
    end

    // Selects the entry for the current call and staging address.
    always_comb begin
        word = rom_w[int'(call_sel) * NODES + int'(addr)];
    end
endmodule

// File: rtl/cfg_seq_fsm.sv
// Module: cfg_seq_fsm
// Sequencer: accepts a start request, steps the staging address once per
// cycle, then issues a one-cycle commit and holds done until the next start.
// Assumes CALLS <= 2**ID_W and NODES >= 2.
module cfg_seq_fsm
    import cfgld_pkg::*;
#(
    parameter int CALLS  = 4,
    parameter int NODES  = 8,
    parameter int ID_W   = 3,
    parameter int CALL_W = 2,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [ID_W-1:0]   call_id,
    output logic [ADDR_W-1:0] addr,
    output logic [CALL_W-1:0] call_q,
    output logic              wr_en,
    output logic              commit,
    output logic              busy,
    output logic              done
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NODES - 1);
    localparam logic [ID_W-1:0]   LAST_ID   = ID_W'(CALLS - 1);

    ld_state_e state_q, state_d;
    logic      id_ok;
    logic      accept;

    // Flags a start request with a call number inside the table.
    always_comb begin
        id_ok  = (call_id <= LAST_ID);
        accept = cfg_en && id_ok && (state_q == ST_IDLE || state_q == ST_DONE);
    end

    // Next-state selection for the load sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (accept) state_d = ST_LOAD;
            ST_LOAD:   if (addr == LAST_ADDR) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_DONE;
            ST_DONE:   if (accept) state_d = ST_LOAD;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Staging address counter and latched call number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            call_q <= '0;
        end else if (accept) begin
            addr   <= '0;
            call_q <= call_id[CALL_W-1:0];
        end else if (state_q == ST_LOAD && addr != LAST_ADDR) begin
            addr   <= addr + ADDR_W'(1);
        end
    end

    // Decodes state into write, commit and status strobes.
    always_comb begin
        wr_en  = (state_q == ST_LOAD);
        commit = (state_q == ST_COMMIT);
        busy   = (state_q == ST_LOAD) || (state_q == ST_COMMIT);
        done   = (state_q == ST_DONE);
    end

    p_commit_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && addr == LAST_ADDR) |=> (state_q == ST_COMMIT));

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && addr != LAST_ADDR) |=> (addr == $past(addr) + ADDR_W'(1)));

    p_call_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |=> $stable(call_q));

    p_bad_id_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !id_ok && state_q == ST_DONE) |=> (state_q == ST_DONE));
endmodule

// File: rtl/cfg_reg_bank.sv
// Module: cfg_reg_bank
// Two-level register bank: decoded writes fill per-node staging registers,
// and a commit strobe copies every staging register to the live register.
// Assumes at most one write per cycle; the commit and write never overlap.
module cfg_reg_bank #(
    parameter int NODES  = 8,
    parameter int WORD_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [WORD_W-1:0]       wr_data,
    input  logic                    commit,
    output logic [NODES*WORD_W-1:0] cfg_flat
);
    logic [NODES*WORD_W-1:0] ld_flat;

    for (genvar g = 0; g < NODES; g++) begin : g_slot
        logic              sel;
        logic [WORD_W-1:0] ld_q;
        logic [WORD_W-1:0] cfg_q;

        // Address decode for this node's staging register.
        always_comb sel = wr_en && (wr_addr == ADDR_W'(g));

        // Staging register, written only when decoded.
        always_ff @(posedge clk) begin
            if (!rst_n)   ld_q <= '0;
            else if (sel) ld_q <= wr_data;
        end

        // Live register, copied from staging on commit.
        always_ff @(posedge clk) begin
            if (!rst_n)      cfg_q <= '0;
            else if (commit) cfg_q <= ld_q;
        end

        assign ld_flat[g*WORD_W +: WORD_W]  = ld_q;
        assign cfg_flat[g*WORD_W +: WORD_W] = cfg_q;
    end

    p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cfg_flat));

    p_cfg_takes_stage_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (cfg_flat == $past(ld_flat)));
endmodule

// File: rtl/route_cfg_stager.sv
// Module: route_cfg_stager
// Top: ties the sequencer, the computed word table and the two-level register
// bank together. The live configuration changes only on the commit edge.
// Assumes call_id and cfg_en are synchronous to clk.
module route_cfg_stager #(
    parameter int NODES  = 8,
    parameter int WORD_W = 8,
    parameter int CALLS  = 4,
    parameter int ID_W   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ID_W-1:0]         call_id,
    input  logic                    cfg_en,
    output logic [NODES*WORD_W-1:0] cfg_bits,
    output logic                    busy,
    output logic                    done
);
    localparam int ADDR_W = (NODES > 1) ? $clog2(NODES) : 1;
    localparam int CALL_W = (CALLS > 1) ? $clog2(CALLS) : 1;

    logic [ADDR_W-1:0] addr;
    logic [CALL_W-1:0] call_q;
    logic              wr_en;
    logic              commit;
    logic [WORD_W-1:0] word;

    cfg_seq_fsm #(
        .CALLS(CALLS), .NODES(NODES), .ID_W(ID_W),
        .CALL_W(CALL_W), .ADDR_W(ADDR_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .call_id(call_id),
        .addr(addr), .call_q(call_q), .wr_en(wr_en), .commit(commit),
        .busy(busy), .done(done)
    );

    cfg_table_rom #(
        .CALLS(CALLS), .NODES(NODES), .WORD_W(WORD_W),
        .CALL_W(CALL_W), .ADDR_W(ADDR_W)
    ) u_rom (
        .call_sel(call_q), .addr(addr), .word(word)
    );

    cfg_reg_bank #(
        .NODES(NODES), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(addr),
        .wr_data(word), .commit(commit), .cfg_flat(cfg_bits)
    );

    p_done_after_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (done && !busy));

    p_idle_bad_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && cfg_en && call_id >= ID_W'(CALLS)) |=> (!busy && !done));

    p_busy_excl_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
endmodule

// File: tb/route_cfg_stager_bench.sv
module route_cfg_stager_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NODES  = 8;
    localparam int WORD_W = 8;
    localparam int ID_W   = 3;

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic [ID_W-1:0]         call_id;
    logic                    cfg_en;
    logic [NODES*WORD_W-1:0] cfg_bits;
    logic                    busy;
    logic                    done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Reference model state: 0 idle, 1 staging, 2 commit, 3 done.
    int                      m_phase = 0;
    int                      m_cnt   = 0;
    int                      m_call  = 0;
    logic [WORD_W-1:0]       m_stage [NODES];
    logic [NODES*WORD_W-1:0] m_cfg   = '0;

    route_cfg_stager #(.NODES(NODES), .WORD_W(WORD_W), .CALLS(4), .ID_W(ID_W))
        u_route_cfg_stager (.clk(clk), .rst_n(rst_n), .call_id(call_id),
                            .cfg_en(cfg_en), .cfg_bits(cfg_bits),
                            .busy(busy), .done(done));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [WORD_W-1:0] table_word(int c, int n);
        int v = (c * 71 + n * 19 + 33) % (1 << WORD_W);
        return v[WORD_W-1:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Advance the reference model at each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_call = 0; m_cfg = '0;
            for (int i = 0; i < NODES; i++) m_stage[i] = '0;
        end else begin
            case (m_phase)
                0, 3: if (cfg_en && call_id < 4) begin
                    m_phase = 1; m_cnt = 0; m_call = int'(call_id);
                end
                1: begin
                    m_stage[m_cnt] = table_word(m_call, m_cnt);
                    if (m_cnt == NODES - 1) m_phase = 2;
                    else m_cnt++;
                end
                default: begin
                    for (int i = 0; i < NODES; i++)
                        m_cfg[i*WORD_W +: WORD_W] = m_stage[i];
                    m_phase = 3;
                end
            endcase
        end
    end

    // Compare outputs to the model on every falling edge.
    always @(negedge clk) begin
        if (cycles > 0) begin
            chk(busy == (m_phase == 1 || m_phase == 2), "R2 busy per cycle",
                64'(busy), 64'(m_phase == 1 || m_phase == 2));
            chk(done == (m_phase == 3), "R5 done per cycle",
                64'(done), 64'(m_phase == 3));
            chk(cfg_bits == m_cfg, "R4 cfg_bits per cycle", cfg_bits, m_cfg);
        end
    end

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic pulse(input int c);
        @(negedge clk);
        cfg_en = 1'b1; call_id = ID_W'(c);
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 40 && !done; i++) @(negedge clk);
    endtask

    task automatic check_fields(input int c, input string tag);
        for (int n = 0; n < NODES; n++)
            chk(cfg_bits[n*WORD_W +: WORD_W] == table_word(c, n), tag,
                64'(cfg_bits[n*WORD_W +: WORD_W]), 64'(table_word(c, n)));
    endtask

    initial begin
        int bc;
        logic [NODES*WORD_W-1:0] snap;
        rst_n = 1'b0; cfg_en = 1'b0; call_id = '0;
        repeat (3) @(negedge clk);
        chk(cfg_bits == '0 && !busy && !done, "R1 reset state", cfg_bits, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_bits == '0 && !busy && !done, "R1 after release", cfg_bits, '0);

        // R6: invalid call from idle.
        pulse(6);
        repeat (2) @(negedge clk);
        chk(!busy && !done && cfg_bits == '0, "R6 idle bad call", 64'(busy), 64'(0));

        // R2/R7: start call 2, count busy cycles, poke enable mid-load.
        @(negedge clk);
        cfg_en = 1'b1; call_id = 3'd2;
        @(negedge clk);
        cfg_en = 1'b0;
        bc = 0;
        for (int i = 0; i < 40 && busy; i++) begin
            if (i == 3) begin cfg_en = 1'b1; call_id = 3'd1; end
            else cfg_en = 1'b0;
            bc++;
            @(negedge clk);
        end
        cfg_en = 1'b0;
        chk(bc == NODES + 1, "R2 busy window length", 64'(bc), 64'(NODES + 1));
        chk(done == 1'b1, "R5 done after commit", 64'(done), 64'(1));
        check_fields(2, "R7 original call kept");

        // R6: invalid call while done.
        snap = cfg_bits;
        pulse(5);
        repeat (2) @(negedge clk);
        chk(done && !busy && cfg_bits == snap, "R6 done bad call", cfg_bits, snap);

        // R8/R3: reload from done with other calls.
        pulse(0);
        chk(!done && busy, "R5 done falls on accept", 64'(done), 64'(0));
        wait_done();
        check_fields(0, "R3 call 0 fields");
        pulse(3);
        wait_done();
        check_fields(3, "R8 call 3 replaces");
        pulse(1);
        wait_done();
        check_fields(1, "R3 call 1 fields");
        repeat (4) @(negedge clk);
        chk(done == 1'b1, "R5 done held", 64'(done), 64'(1));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule